// File: doc/BRIEF.md
# BCD Clock-Calendar with Hundredths

This block is the counting core of a real-time clock. It takes a clock enable that pulses at 32.768 kHz and derives a 100 Hz step from it. It then advances nine packed-BCD fields once per step: hundredths, seconds, minutes, hours (24-hour), weekday, date, month, year and century. Date rollover follows the length of each month. February has 29 days in every year whose two-digit value is a multiple of 4, and year 00 counts as one of those.

A host sets any field by presenting a field number and a BCD byte for one cycle. Every load restarts the fractional 100 Hz accumulator. The next hundredth therefore arrives a full 328 enables after the load. For reads, the host raises a snapshot request. All nine fields are copied together into a set of holding registers, so a carry that ripples across several fields can never be seen half done.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the snapshot outputs read hundredths 00, seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00 and century equal to the parameter RESET_CENT (default 20).
- R2: Each enable adds 100 to an accumulator. When the sum reaches 32768, 32768 is subtracted and the hundredths field advances at that same clock edge. After a load, the first advance happens on the 328th enable. Any 32768 consecutive enables after a load give exactly 100 advances.
- R3: Hundredths count 00..99, seconds and minutes count 00..59, and hours count 00..23. Each field wraps to 00 and carries into the next field at the edge where it wraps.
- R4: The weekday counts 01..07. It advances, wrapping from 07 to 01, at the same edge as the hour wrap.
- R5: The date counts from 01 up to 30 in months 04, 06, 09 and 11, and up to 31 in the other months except 02. After the last day it becomes 01 and the month advances.
- R6: In month 02 the date runs up to 29 when the year value is divisible by 4 (year 00 included), and up to 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century. Century 99 wraps to 00.
- R8: A load writes its byte into the field chosen by the field number at the next edge. The field numbers are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year and 8 century. Field numbers 9..15 change no field. A load takes priority over a step in that cycle, and every load clears the accumulator.
- R9: When a snapshot is requested, the snapshot outputs take the values the nine fields held just before that edge. Without a request they hold their value.
- R10: With the tick enable low, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz rate |
| ld_en | input | 1 | Load strobe |
| ld_field | input | 4 | Field number to load (R8 encoding) |
| ld_byte | input | 8 | BCD value to load |
| snap_req | input | 1 | Snapshot request |
| snap_hund | output | 8 | Captured hundredths, BCD |
| snap_sec | output | 8 | Captured seconds, BCD |
| snap_min | output | 8 | Captured minutes, BCD |
| snap_hour | output | 8 | Captured hours, BCD |
| snap_wday | output | 8 | Captured weekday, BCD 01..07 |
| snap_date | output | 8 | Captured date, BCD |
| snap_month | output | 8 | Captured month, BCD |
| snap_year | output | 8 | Captured year, BCD |
| snap_cent | output | 8 | Captured century, BCD |

## Verification
A free run of 32768 enables from a fresh load shows whether the accumulator gives exactly one second. Loaded times just before each rollover point separate the carry paths. These include 23:59:59.98, weekday 07, April 30, January 31, February 28 and 29 in the years 24, 23 and 00, and December 31 of year 99 in century 99. Repeated loads to an unused field number show that the accumulator clears while no field moves. Phases with the snapshot request low and with the enable low separate holding from counting.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_FIELDS = 9;

    typedef logic [7:0] bcd8_t;

    typedef enum logic [3:0] {
        F_HUND  = 4'd0,
        F_SEC   = 4'd1,
        F_MIN   = 4'd2,
        F_HOUR  = 4'd3,
        F_WDAY  = 4'd4,
        F_DATE  = 4'd5,
        F_MONTH = 4'd6,
        F_YEAR  = 4'd7,
        F_CENT  = 4'd8
    } rtc_field_e;

    // add one to a packed two-digit BCD value
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // lowest legal value of a field
    function automatic bcd8_t field_min(input int idx);
        bcd8_t r;
        if (idx == int'(F_WDAY) || idx == int'(F_DATE) || idx == int'(F_MONTH))
            r = 8'h01;
        else
            r = 8'h00;
        return r;
    endfunction

    // highest legal value of a field with a fixed range (date is computed)
    function automatic bcd8_t field_top(input int idx);
        bcd8_t r;
        case (idx)
            int'(F_HUND):  r = 8'h99;
            int'(F_SEC):   r = 8'h59;
            int'(F_MIN):   r = 8'h59;
            int'(F_HOUR):  r = 8'h23;
            int'(F_WDAY):  r = 8'h07;
            int'(F_MONTH): r = 8'h12;
            default:       r = 8'h99;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_frac_tick.sv
module rtc_frac_tick #(
    parameter int TICK_HZ = 32768,
    parameter int STEP_HZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr,
    output logic step_o
);
    localparam int AW = $clog2(TICK_HZ + STEP_HZ) + 1;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;

    always_comb begin
        sum    = acc_q + AW'(STEP_HZ);
        step_o = tick_en && !clr && (sum >= AW'(TICK_HZ));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc_q <= '0;
        else if (clr)       acc_q <= '0;
        else if (step_o)    acc_q <= sum - AW'(TICK_HZ);
        else if (tick_en)   acc_q <= sum;
    end

    // R2: remainder always below the modulus
    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < AW'(TICK_HZ));

    // R2: a step cannot follow a step on the very next cycle
    p_no_double_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R8: a load leaves the accumulator empty
    p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_q == '0);

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  bcd8_t month,
    input  bcd8_t year,
    output bcd8_t last_day
);
    logic [4:0] mod_sum;
    logic       leap;

    always_comb begin
        // (10*hi + lo) mod 4 equals (2*hi + lo) mod 4
        mod_sum = {year[7:4], 1'b0} + {1'b0, year[3:0]};
        leap    = (mod_sum[1:0] == 2'b00);
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt
    import rtc_pkg::*;
#(
    parameter bcd8_t MIN_VAL = 8'h00,
    parameter bcd8_t RST_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc_i,
    input  logic  ld_i,
    input  bcd8_t ld_val_i,
    input  bcd8_t lim_i,
    output bcd8_t q_o,
    output logic  wrap_o
);
    assign wrap_o = inc_i && (q_o >= lim_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= RST_VAL;
        else if (ld_i)   q_o <= ld_val_i;
        else if (wrap_o) q_o <= MIN_VAL;
        else if (inc_i)  q_o <= bcd_inc(q_o);
    end

    // R10: no step and no load means no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i) |=> $stable(q_o));

    // R3: a wrap lands on the field's lowest value
    p_wrap_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !ld_i) |=> q_o == MIN_VAL);

    // R8: a loaded byte appears one edge later
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> q_o == $past(ld_val_i));

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
    import rtc_pkg::*;
#(
    parameter int    TICK_HZ    = 32768,
    parameter int    STEP_HZ    = 100,
    parameter bcd8_t RESET_CENT = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       ld_en,
    input  logic [3:0] ld_field,
    input  logic [7:0] ld_byte,
    input  logic       snap_req,
    output logic [7:0] snap_hund,
    output logic [7:0] snap_sec,
    output logic [7:0] snap_min,
    output logic [7:0] snap_hour,
    output logic [7:0] snap_wday,
    output logic [7:0] snap_date,
    output logic [7:0] snap_month,
    output logic [7:0] snap_year,
    output logic [7:0] snap_cent
);
    logic                  step;
    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] carry;
    logic [NUM_FIELDS-1:0] ld_hit;
    bcd8_t                 live [NUM_FIELDS];
    bcd8_t                 lim  [NUM_FIELDS];
    bcd8_t                 snap [NUM_FIELDS];
    bcd8_t                 date_last;

    rtc_frac_tick #(
        .TICK_HZ (TICK_HZ),
        .STEP_HZ (STEP_HZ)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (ld_en),
        .step_o  (step)
    );

    rtc_month_len u_mlen (
        .month    (live[F_MONTH]),
        .year     (live[F_YEAR]),
        .last_day (date_last)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        logic src;
        if (i == 0) begin : g_src_step
            assign src = step;
        end else if (i == int'(F_WDAY)) begin : g_src_day
            assign src = carry[F_HOUR];
        end else if (i == int'(F_DATE)) begin : g_src_date
            // weekday only moves when the hour wraps, so this equals carry[F_HOUR]
            assign src = carry[F_HOUR] | carry[F_WDAY];
        end else begin : g_src_chain
            assign src = carry[i-1];
        end

        if (i == int'(F_DATE)) begin : g_lim_dyn
            assign lim[i] = date_last;
        end else begin : g_lim_fix
            assign lim[i] = field_top(i);
        end

        assign inc[i]    = src && !ld_en;
        assign ld_hit[i] = ld_en && (ld_field == 4'(i));

        rtc_wrap_cnt #(
            .MIN_VAL (field_min(i)),
            .RST_VAL ((i == int'(F_CENT)) ? RESET_CENT : field_min(i))
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[i]),
            .ld_i     (ld_hit[i]),
            .ld_val_i (ld_byte),
            .lim_i    (lim[i]),
            .q_o      (live[i]),
            .wrap_o   (carry[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        snap[i] <= (i == int'(F_CENT)) ? RESET_CENT : field_min(i);
            else if (snap_req) snap[i] <= live[i];
        end
    end

    assign snap_hund  = snap[F_HUND];
    assign snap_sec   = snap[F_SEC];
    assign snap_min   = snap[F_MIN];
    assign snap_hour  = snap[F_HOUR];
    assign snap_wday  = snap[F_WDAY];
    assign snap_date  = snap[F_DATE];
    assign snap_month = snap[F_MONTH];
    assign snap_year  = snap[F_YEAR];
    assign snap_cent  = snap[F_CENT];

    // R9: captured minutes match the live value before the edge
    p_snap_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap_min == $past(live[F_MIN]));

    // R9: no request, no change on the hold registers
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> ($stable(snap_sec) && $stable(snap_date)));

    // R8: a load never coincides with a field advance
    p_load_blocks_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> inc == '0);

    // R4: weekday and date move together on a day change
    p_day_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc[F_WDAY] == inc[F_DATE]);

endmodule

// File: tb/sim_rtc_bcd_clock.sv
`timescale 1ns/1ps
module sim_rtc_bcd_clock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_field = 4'd0;
    logic [7:0] ld_byte = 8'h00;
    logic       snap_req = 1'b1;
    logic [7:0] o_h, o_s, o_mi, o_hr, o_wd, o_d, o_mo, o_y, o_c;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit comparing = 1'b0;
    string cur_req = "R1";

    // reference model, decimal integers indexed by field number
    int m_live [9];
    int m_snap [9];
    int m_acc;

    always #2 clk = ~clk;

    rtc_bcd_clock u0 (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .ld_en (ld_en), .ld_field (ld_field), .ld_byte (ld_byte),
        .snap_req (snap_req),
        .snap_hund (o_h), .snap_sec (o_s), .snap_min (o_mi), .snap_hour (o_hr),
        .snap_wday (o_wd), .snap_date (o_d), .snap_month (o_mo),
        .snap_year (o_y), .snap_cent (o_c)
    );

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_live = '{0, 0, 0, 0, 1, 1, 1, 0, 20};
        m_snap = m_live;
        m_acc  = 0;
    endtask

    task automatic model_advance();
        m_live[0]++;
        if (m_live[0] > 99) begin
            m_live[0] = 0; m_live[1]++;
            if (m_live[1] > 59) begin
                m_live[1] = 0; m_live[2]++;
                if (m_live[2] > 59) begin
                    m_live[2] = 0; m_live[3]++;
                    if (m_live[3] > 23) begin
                        m_live[3] = 0;
                        m_live[4] = (m_live[4] == 7) ? 1 : m_live[4] + 1;
                        m_live[5]++;
                        if (m_live[5] > month_days(m_live[6], m_live[7])) begin
                            m_live[5] = 1; m_live[6]++;
                            if (m_live[6] > 12) begin
                                m_live[6] = 1; m_live[7]++;
                                if (m_live[7] > 99) begin
                                    m_live[7] = 0;
                                    m_live[8] = (m_live[8] + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            model_reset();
        end else begin
            if (snap_req) m_snap = m_live;
            if (ld_en) begin
                if (ld_field <= 4'd8) m_live[ld_field] = from_bcd(ld_byte);
                m_acc = 0;
            end else if (tick_en) begin
                m_acc += 100;
                if (m_acc >= 32768) begin
                    m_acc -= 32768;
                    model_advance();
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (comparing) begin
            logic [7:0] got [9];
            got = '{o_h, o_s, o_mi, o_hr, o_wd, o_d, o_mo, o_y, o_c};
            n_checks++;
            for (int k = 0; k < 9; k++) begin
                if (got[k] !== 8'(to_bcd(m_snap[k]))) begin
                    n_fail++;
                    $display("FAIL %s field %0d actual=%02h expected=%02h at cycle %0d",
                             cur_req, k, got[k], 8'(to_bcd(m_snap[k])), cycles);
                    break;
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic load(input int fld, input int dec_val);
        @(negedge clk);
        ld_en = 1'b1; ld_field = 4'(fld); ld_byte = 8'(to_bcd(dec_val));
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_raw(input int fld, input logic [7:0] b);
        @(negedge clk);
        ld_en = 1'b1; ld_field = 4'(fld); ld_byte = b;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_day_end(input int d, input int mo, input int y);
        load(7, y); load(6, mo); load(5, d);
        load(3, 23); load(2, 59); load(1, 59); load(0, 99);
    endtask

    initial begin
        // R1: reset values
        cur_req = "R1";
        run(3);
        @(negedge clk); rst_n = 1'b1; comparing = 1'b1;
        run(4);

        // R2: one full second of enables from a fresh load
        cur_req = "R2";
        tick_en = 1'b1;
        load(0, 0);
        run(32768 + 700);

        // R3: carries through seconds, minutes, hours
        cur_req = "R3";
        load(4, 3); load(5, 15); load(6, 5); load(7, 25);
        load(3, 23); load(2, 59); load(1, 59); load(0, 98);
        run(800);

        // R4: weekday 7 wraps to 1
        cur_req = "R4";
        load(4, 7);
        set_day_end(10, 3, 25);
        run(400);

        // R5: 30- and 31-day months
        cur_req = "R5";
        set_day_end(30, 4, 25);
        run(400);
        set_day_end(31, 1, 25);
        run(400);
        set_day_end(30, 11, 25);
        run(400);

        // R6: February in leap, common and year-00
        cur_req = "R6";
        set_day_end(28, 2, 24);
        run(400);
        set_day_end(29, 2, 24);
        run(400);
        set_day_end(28, 2, 23);
        run(400);
        set_day_end(28, 2, 0);
        run(400);

        // R7: year and century rollover
        cur_req = "R7";
        load(8, 99);
        set_day_end(31, 12, 99);
        run(400);
        load(8, 19);
        set_day_end(31, 12, 99);
        run(400);

        // R8: unused field numbers keep clearing the accumulator
        cur_req = "R8";
        load(0, 50);
        for (int k = 0; k < 12; k++) begin
            load_raw(9 + (k % 7), 8'h55);
            run(300);
        end
        load(0, 97);
        run(330);
        load(1, 42);

        // R9: hold without request, then capture again
        cur_req = "R9";
        snap_req = 1'b0;
        run(1500);
        snap_req = 1'b1;
        run(20);

        // R10: no enables, no motion
        cur_req = "R10";
        tick_en = 1'b0;
        run(2000);

        comparing = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule